// File: doc/BRIEF.md
# Register-indirect address sequencer with auto-update and byte pairing

This block sits between the register file and the memory port of a 16-bit processor with eight registers. R7 is the program counter and R6 the stack pointer. For a memory reference that takes its address from a register, the requester gives the block the 3-bit register code, the current register value, a write flag and (for writes) the data. The block runs the memory handshake and returns the read result. It also returns the value that the chosen register must hold afterwards, on a write-back port.

The update depends on the register. R1 to R3 are never changed. R4, R5 and R7 step up by one after the access. R6 acts as an upward-growing stack: a write uses the current value and then steps up, while a read steps down first and then uses the new value.

A one-shot prefix (`dbl_arm`) makes the next accepted request a byte-pair read. It performs two accesses and keeps only the low byte of each fetched word. The first byte becomes result bits 7:0 and the second becomes bits 15:8. Through R1 to R3 the same word is read twice. Through R4, R5 or R7 two neighbouring words are read and the register advances by two; with R7 this fetches an immediate operand from two program words. Register code 0 stands for direct addressing, which this block does not serve. Code 0, a byte-pair access through R6, and a byte-pair write are all rejected with an error pulse, and no access takes place.

Top module: `indirect_agu`

## Requirements
- R1: After synchronous reset, `done`, `err`, `wb_en` and `mem_req` are low, and the byte-pair prefix is clear.
- R2: For register codes 1, 2 and 3, the single access uses the supplied register value as the address, and `wb_en` stays low.
- R3: For codes 4, 5 and 7, the single access uses the register value as the address, and the write-back carries that value plus one (modulo 2^16).
- R4: For code 6, a write goes to the register value and writes back value plus one; a read goes to value minus one and writes back value minus one (modulo 2^16).
- R5: A byte-pair read through codes 1 to 3 reads the same address twice, returns {second low byte, first low byte}, and does not assert `wb_en`.
- R6: A byte-pair read through codes 4, 5 or 7 reads address v and then v+1, returns {low byte of word at v+1, low byte of word at v}, and writes back v+2 (all modulo 2^16).
- R7: Code 0, a byte-pair request through code 6, and a byte-pair write each give `err` high for exactly one cycle, in the cycle after acceptance. In these cases `mem_req`, `done` and `wb_en` stay low.
- R8: A `dbl_arm` pulse applies to exactly the next accepted request only, and that request consumes it even when it is rejected. Repeated pulses before that request still give one byte-pair request.
- R9: `mem_req` stays high with a stable address, write flag and write data until `mem_ack`. `done` and the write-back appear in the single cycle after the final acknowledged access: L+2 cycles after acceptance for a single access and 2L+4 for a byte pair, where L is the number of cycles the memory waits before acknowledging.
- R10: A request raised while an access is in progress is ignored and causes no extra access, write-back or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbl_arm | input | 1 | Arms byte-pair mode for the next accepted request |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_sel | input | 3 | Register code supplying the address (0 = direct, rejected) |
| req_write | input | 1 | 1 = memory write, 0 = read |
| req_wdata | input | 16 | Data to write |
| req_base | input | 16 | Current value of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the current access |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rd_data | output | 16 | Read result, valid with `done` on reads |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | 3 | Register to update |
| wb_val | output | 16 | New register value |

## Verification
A corrupted latched address or update rule shows up on `mem_addr` at the very first acknowledged access, or on `wb_val` one cycle after the last one. A byte-pair flag that is stuck or not consumed changes the number of accesses, so `done` comes early or late by at least L+2 cycles. A wrong byte order shows as swapped halves in `rd_data` in the `done` cycle. A bad state transition shows up as a second unexpected `mem_req`, or as `done` outside a transaction, within a cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        RULE_DIRECT  = 2'd0,
        RULE_FIXED   = 2'd1,
        RULE_POSTINC = 2'd2,
        RULE_STACK   = 2'd3
    } upd_rule_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT1 = 2'd1,
        ST_WAIT2 = 2'd2
    } seq_state_e;

    function automatic upd_rule_e rule_of(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:                 return RULE_DIRECT;
            3'd1, 3'd2, 3'd3:     return RULE_FIXED;
            3'd6:                 return RULE_STACK;
            default:              return RULE_POSTINC;
        endcase
    endfunction

endpackage

// File: rtl/agu_prefix_flag.sv
module agu_prefix_flag (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic consume,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (consume) flag <= arm;
        else if (arm)     flag <= 1'b1;
    end

    a_r8_consumed: assert property (@(posedge clk) disable iff (rst)
        (consume && !arm) |=> !flag);
    a_r8_armed: assert property (@(posedge clk) disable iff (rst)
        arm |=> flag);
endmodule

// File: rtl/agu_addr_rules.sv
module agu_addr_rules
    import agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              write,
    input  logic              dbl,
    input  logic [DATA_W-1:0] base,
    output logic              illegal,
    output logic [DATA_W-1:0] addr1,
    output logic [DATA_W-1:0] addr2,
    output logic              wb_need,
    output logic [DATA_W-1:0] wb_next
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    upd_rule_e rule;

    always_comb begin
        rule    = rule_of(sel);
        illegal = (rule == RULE_DIRECT) || (dbl && (write || rule == RULE_STACK));
        addr1   = base;
        addr2   = base;
        wb_need = 1'b0;
        wb_next = base;
        case (rule)
            RULE_POSTINC: begin
                addr2   = base + ONE;
                wb_need = 1'b1;
                wb_next = dbl ? base + TWO : base + ONE;
            end
            RULE_STACK: begin
                wb_need = 1'b1;
                if (write) begin
                    wb_next = base + ONE;
                end else begin
                    addr1   = base - ONE;
                    wb_next = base - ONE;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              illegal,
    input  logic              dbl,
    input  logic              write,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] addr1,
    input  logic [DATA_W-1:0] addr2,
    input  logic              wb_need,
    input  logic [DATA_W-1:0] wb_next,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              wb_en,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [DATA_W-1:0] wb_val
);
    localparam int HI_W = DATA_W - BYTE_W;

    seq_state_e              state;
    logic                    pair_q;
    logic                    wb_need_q;
    logic [DATA_W-1:0]       addr2_q;
    logic [DATA_W-1:0]       wb_next_q;
    logic [BYTE_W-1:0]       low_q;

    assign idle    = (state == ST_IDLE);
    assign mem_req = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pair_q    <= 1'b0;
            wb_need_q <= 1'b0;
            addr2_q   <= '0;
            wb_next_q <= '0;
            low_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_data   <= '0;
            wb_en     <= 1'b0;
            wb_sel    <= '0;
            wb_val    <= '0;
        end else begin
            done  <= 1'b0;
            err   <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (illegal) begin
                        err <= 1'b1;
                    end else begin
                        state     <= ST_WAIT1;
                        pair_q    <= dbl;
                        wb_need_q <= wb_need;
                        addr2_q   <= addr2;
                        wb_next_q <= wb_next;
                        mem_we    <= write;
                        mem_addr  <= addr1;
                        mem_wdata <= wdata;
                        wb_sel    <= sel;
                    end
                end
                ST_WAIT1: if (mem_ack) begin
                    if (pair_q) begin
                        low_q    <= mem_rdata[BYTE_W-1:0];
                        mem_addr <= addr2_q;
                        state    <= ST_WAIT2;
                    end else begin
                        rd_data <= mem_rdata;
                        done    <= 1'b1;
                        wb_en   <= wb_need_q;
                        wb_val  <= wb_next_q;
                        state   <= ST_IDLE;
                    end
                end
                ST_WAIT2: if (mem_ack) begin
                    rd_data <= {HI_W'(mem_rdata[BYTE_W-1:0]), low_q};
                    done    <= 1'b1;
                    wb_en   <= wb_need_q;
                    wb_val  <= wb_next_q;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !(state == ST_WAIT1 && pair_q && mem_ack))
        |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!mem_req && !done && !wb_en));
    a_r2_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
    a_r10_no_req_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

// File: rtl/indirect_agu.sv
module indirect_agu
    import agu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbl_arm,
    input  logic              req_valid,
    input  logic [2:0]        req_sel,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              wb_en,
    output logic [2:0]        wb_sel,
    output logic [DATA_W-1:0] wb_val
);
    logic              idle;
    logic              accept;
    logic              dbl_flag;
    logic              illegal;
    logic              wb_need;
    logic [DATA_W-1:0] addr1;
    logic [DATA_W-1:0] addr2;
    logic [DATA_W-1:0] wb_next;

    assign accept = req_valid && idle;

    agu_prefix_flag u_prefix (
        .clk     (clk),
        .rst     (rst),
        .arm     (dbl_arm),
        .consume (accept),
        .flag    (dbl_flag)
    );

    agu_addr_rules #(.DATA_W(DATA_W)) u_rules (
        .sel     (req_sel),
        .write   (req_write),
        .dbl     (dbl_flag),
        .base    (req_base),
        .illegal (illegal),
        .addr1   (addr1),
        .addr2   (addr2),
        .wb_need (wb_need),
        .wb_next (wb_next)
    );

    agu_seq #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .illegal   (illegal),
        .dbl       (dbl_flag),
        .write     (req_write),
        .sel       (req_sel),
        .wdata     (req_wdata),
        .addr1     (addr1),
        .addr2     (addr2),
        .wb_need   (wb_need),
        .wb_next   (wb_next),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data),
        .wb_en     (wb_en),
        .wb_sel    (wb_sel),
        .wb_val    (wb_val)
    );
endmodule

// File: tb/test_indirect_agu.sv
module test_indirect_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbl_arm = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_base = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done, err, wb_en;
    logic [15:0] rd_data, wb_val;
    logic [2:0]  wb_sel;

    int          n_checks = 0;
    int          n_fail = 0;
    int          lat_cfg = 0;
    int          wait_cnt = 0;
    bit          in_txn = 0;
    bit          model_flag = 0;
    logic [15:0] got_a[$];
    logic        got_we[$];
    logic [15:0] got_wd[$];

    always #2 clk = ~clk;

    indirect_agu i_indirect_agu (
        .clk(clk), .rst(rst), .dbl_arm(dbl_arm), .req_valid(req_valid),
        .req_sel(req_sel), .req_write(req_write), .req_wdata(req_wdata),
        .req_base(req_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .err(err), .rd_data(rd_data),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
    );

    function automatic logic [15:0] mf(input logic [15:0] a);
        return {a[15:8] ^ 8'h96, (a[7:0] + 8'h21) ^ a[15:8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and per-clock watch
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else begin
            if (!in_txn && (mem_req || done || err))
                chk(1'b0, "R10 activity outside transaction", {mem_req, done, err}, 0);
            if (mem_ack) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt >= lat_cfg) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mf(mem_addr);
                    got_a.push_back(mem_addr);
                    got_we.push_back(mem_we);
                    got_wd.push_back(mem_wdata);
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic arm();
        @(negedge clk); dbl_arm = 1'b1;
        @(negedge clk); dbl_arm = 1'b0;
        model_flag = 1;
    endtask

    task automatic do_req(input string tag, input logic [2:0] sel, input bit wr,
                          input logic [15:0] base, input int lat, input bit extra);
        bit          dbl, e_err, e_wb;
        int          e_n, k;
        logic [15:0] a1, a2, e_wbv, e_res, wd;
        dbl = model_flag;
        model_flag = 0;
        wd = base ^ 16'h5AA5;
        e_err = (sel == 0) || (dbl && (wr || sel == 6));
        a1 = base; a2 = base; e_wb = 0; e_wbv = base;
        if (sel == 4 || sel == 5 || sel == 7) begin
            a2 = base + 16'd1; e_wb = 1; e_wbv = dbl ? base + 16'd2 : base + 16'd1;
        end else if (sel == 6) begin
            e_wb = 1;
            if (wr) e_wbv = base + 16'd1;
            else begin a1 = base - 16'd1; e_wbv = base - 16'd1; end
        end
        e_n = e_err ? 0 : (dbl ? 2 : 1);
        e_res = dbl ? {mf(a2)[7:0], mf(a1)[7:0]} : mf(a1);
        got_a.delete(); got_we.delete(); got_wd.delete();
        lat_cfg = lat;
        in_txn = 1;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_write = wr; req_base = base; req_wdata = wd;
        @(negedge clk);
        k = 1;
        req_valid = 1'b0;
        if (extra) begin
            req_valid = 1'b1; req_sel = 3'd4; req_base = 16'h7777; req_write = 1'b0;
            @(negedge clk); k++;
            @(negedge clk); k++;
            req_valid = 1'b0;
        end
        while (!(done || err) && k < 60) begin
            @(negedge clk); k++;
        end
        chk(err == e_err, {tag, " err"}, err, e_err);
        chk(got_a.size() == e_n, {tag, " access count"}, got_a.size(), e_n);
        if (!e_err) begin
            chk(k == (dbl ? 4 + 2*lat : 2 + lat), "R9 done timing", k, dbl ? 4 + 2*lat : 2 + lat);
            if (got_a.size() > 0) chk(got_a[0] == a1, {tag, " first address"}, got_a[0], a1);
            if (got_a.size() > 1) chk(got_a[1] == a2, {tag, " second address"}, got_a[1], a2);
            if (got_a.size() > 0) chk(got_we[0] == wr, {tag, " write flag"}, got_we[0], wr);
            if (wr && got_a.size() > 0) chk(got_wd[0] == wd, {tag, " write data"}, got_wd[0], wd);
            if (!wr) chk(rd_data == e_res, {tag, " result"}, rd_data, e_res);
            chk(wb_en == e_wb, {tag, " wb_en"}, wb_en, e_wb);
            if (e_wb) begin
                chk(wb_val == e_wbv, {tag, " wb_val"}, wb_val, e_wbv);
                chk(wb_sel == sel, {tag, " wb_sel"}, wb_sel, sel);
            end
        end else begin
            chk(!done && !wb_en && !mem_req, "R7 no activity on reject", {done, wb_en, mem_req}, 0);
        end
        @(negedge clk);
        chk(!done && !err, {tag, " single-cycle pulse"}, {done, err}, 0);
        in_txn = 0;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !err && !wb_en && !mem_req, "R1 reset outputs", {done, err, wb_en, mem_req}, 0);
        do_req("R1 flag clear after reset", 3'd4, 1'b0, 16'h0100, 0, 0);
        // fixed registers
        do_req("R2 R1 read", 3'd1, 1'b0, 16'h1234, 0, 0);
        do_req("R2 R3 write", 3'd3, 1'b1, 16'hBEEF, 2, 0);
        // post-increment registers
        do_req("R3 R4 read", 3'd4, 1'b0, 16'h2000, 1, 0);
        do_req("R3 R5 write", 3'd5, 1'b1, 16'hFFFF, 0, 0);
        do_req("R3 R7 read", 3'd7, 1'b0, 16'h0040, 3, 0);
        // stack register
        do_req("R4 R6 write", 3'd6, 1'b1, 16'h0300, 1, 0);
        do_req("R4 R6 read wrap", 3'd6, 1'b0, 16'h0000, 0, 0);
        do_req("R4 R6 read", 3'd6, 1'b0, 16'h0305, 2, 0);
        // byte pairs
        arm(); do_req("R5 pair R2", 3'd2, 1'b0, 16'h4321, 1, 0);
        arm(); do_req("R6 pair R5 wrap", 3'd5, 1'b0, 16'h80FF, 0, 0);
        arm(); do_req("R6 pair R4", 3'd4, 1'b0, 16'hFFFF, 2, 0);
        arm(); do_req("R6 pair R7 immediate", 3'd7, 1'b0, 16'h1FFE, 1, 0);
        // rejects
        do_req("R7 direct code", 3'd0, 1'b0, 16'h0555, 0, 0);
        arm(); do_req("R7 pair R6", 3'd6, 1'b0, 16'h0400, 0, 0);
        do_req("R8 flag consumed by reject", 3'd1, 1'b0, 16'h0777, 0, 0);
        arm(); do_req("R7 pair write", 3'd4, 1'b1, 16'h0600, 0, 0);
        do_req("R8 flag consumed after write reject", 3'd5, 1'b0, 16'h0900, 1, 0);
        // repeated arming then one request
        arm(); arm(); do_req("R8 double arm", 3'd5, 1'b0, 16'h0A10, 0, 0);
        do_req("R8 only one pair", 3'd5, 1'b0, 16'h0A12, 0, 0);
        // busy requests ignored
        do_req("R10 busy request ignored", 3'd1, 1'b0, 16'h0C00, 3, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule